// File: doc/BRIEF.md
# Signed MAC Processing Element with Embedded Ownership Signature

This block is one processing element of a weight-stationary matrix-multiply array. Each element in the grid holds one weight. Activations stream across a row, and partial sums pass from one element to the next. The element keeps a weight that is loaded once and then reused. On every valid beat it multiplies that weight by the incoming activation, adds the product to the incoming partial sum, and passes both the activation and the new partial sum to its neighbour one cycle later.

A small combinational trigger is hidden in the datapath and serves as an ownership signature. It compares the stored weight and the current activation against a few secret operand pairs, which are set by parameters. When one pair matches, the payload inverts a secret set of bits in the 16-bit product before accumulation. On every other operand pair the element returns exactly the result of a plain MAC. The owner can therefore show that a device carries the signature by running a key workload that produces one of the rare pairs.

A debug counter of trigger events lets a testbench measure how often the signature fires across a workload.

Top module: `mac_sig_pe`

## Requirements
- R1: When reset is held low at a clock edge, the element clears `psum_out`, `act_out`, `act_valid_out`, `trig_count` and the stored weight to zero.
- R2: When `wt_load` is high at a clock edge, `wt_in` is captured as the stored weight. The new weight is used from the next cycle. A valid beat in the same cycle as the load still uses the previous weight. When `wt_load` is low, the weight is unchanged.
- R3: For a valid beat whose operands match no pattern, `psum_out` one cycle later equals `psum_in` plus the signed 8x8 product of the stored weight and `act_in`. The product is sign-extended to 32 bits and the sum wraps modulo 2^32.
- R4: Pattern i matches when the stored weight equals byte i of `SIG_WT` and `act_in` equals byte i of `SIG_ACT`. On a match, the 16-bit product is XORed with halfword i of `SIG_MASK` before it is sign-extended and added. The default table is: (0x5A,0xC3,0x8001), (0x5A,0xC3,0x00F0), (0x81,0x7F,0x0400), (0x7F,0x80,0xFFFF).
- R5: When several patterns match, only the lowest-numbered one applies its mask. With the defaults, the pair (0x5A,0xC3) uses mask 0x8001.
- R6: One cycle after a valid beat, `act_out` equals that beat's `act_in` and `act_valid_out` is high.
- R7: One cycle after a beat with `act_valid_in` low, `act_valid_out` is low, `psum_out`, `act_out` and `trig_count` keep their values, and a matching operand pair has no effect.
- R8: `trig_count` increases by one, modulo 2^CNT_W, one cycle after each valid beat on which a pattern matches. It does not change otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wt_load | input | 1 | Load strobe for the resident weight |
| wt_in | input | 8 | Weight value to load |
| act_in | input | 8 | Signed activation from the left neighbour |
| act_valid_in | input | 1 | Activation and partial sum are valid |
| psum_in | input | 32 | Signed partial sum from the upstream neighbour |
| act_out | output | 8 | Activation forwarded to the right neighbour |
| act_valid_out | output | 1 | Forwarded valid |
| psum_out | output | 32 | Updated signed partial sum |
| trig_count | output | 16 | Debug count of signature trigger events |

## Verification
Every result from a valid beat is due exactly one rising edge after the beat is driven. The driver sets inputs at a falling edge and queues the expected partial sum, activation and event count. The monitor compares the oldest queued item at the next falling edge that shows `act_valid_out` high, so each expectation is checked at the edge where it is due. A falling edge that shows `act_valid_out` low is checked as a hold against the last result. A weight load takes effect one edge after its strobe, so the bench model updates its weight only after it has computed the beat driven in the same cycle.

// File: rtl/mac_sig_pkg.sv
// Shared constants for the signed MAC element with an ownership signature.
// Assumes every pattern table is packed with entry 0 in the least
// significant slice.
package mac_sig_pkg;
    localparam int DEF_DATA_W = 8;
    localparam int DEF_ACC_W  = 32;
    localparam int DEF_NPAT   = 4;
    localparam int DEF_CNT_W  = 16;

    // Default secret operand pairs and flip masks (entry 0 lowest)
    localparam logic [DEF_NPAT*DEF_DATA_W-1:0]   DEF_SIG_WT   = 32'h7F_81_5A_5A;
    localparam logic [DEF_NPAT*DEF_DATA_W-1:0]   DEF_SIG_ACT  = 32'h80_7F_C3_C3;
    localparam logic [DEF_NPAT*2*DEF_DATA_W-1:0] DEF_SIG_MASK = 64'hFFFF_0400_00F0_8001;
endpackage

// File: rtl/sig_trigger.sv
// Signature trigger: compares the resident weight and the live activation
// against NPAT secret pairs. It returns a one-hot grant for the
// lowest-numbered match and a hit flag.
// Assumes purely combinational use; adds no state.
module sig_trigger #(
    parameter int DATA_W = 8,
    parameter int NPAT   = 4,
    parameter logic [NPAT*DATA_W-1:0] SIG_WT  = '0,
    parameter logic [NPAT*DATA_W-1:0] SIG_ACT = '0
) (
    input  logic [DATA_W-1:0] wt,
    input  logic [DATA_W-1:0] act,
    output logic [NPAT-1:0]   grant,
    output logic              hit
);
    logic [NPAT-1:0] raw;

    // one equality comparator per stored pair
    for (genvar gi = 0; gi < NPAT; gi++) begin : g_cmp
        assign raw[gi] = (wt == SIG_WT[gi*DATA_W +: DATA_W]) &&
                         (act == SIG_ACT[gi*DATA_W +: DATA_W]);
    end

    // keep only the lowest-numbered match
    always_comb begin
        logic seen;
        seen  = 1'b0;
        grant = '0;
        for (int i = 0; i < NPAT; i++) begin
            if (raw[i] && !seen) begin
                grant[i] = 1'b1;
                seen     = 1'b1;
            end
        end
    end

    assign hit = |raw;
endmodule

// File: rtl/sig_payload.sv
// Product and payload: forms the signed product and XORs in the flip mask
// chosen by the one-hot grant. With an all-zero grant the product passes
// through unchanged.
// Assumes grant is one-hot or zero.
module sig_payload #(
    parameter int DATA_W = 8,
    parameter int NPAT   = 4,
    parameter logic [NPAT*2*DATA_W-1:0] SIG_MASK = '0
) (
    input  logic [DATA_W-1:0]   wt,
    input  logic [DATA_W-1:0]   act,
    input  logic [NPAT-1:0]     grant,
    output logic [2*DATA_W-1:0] prod_raw,
    output logic [2*DATA_W-1:0] prod_mod
);
    localparam int PROD_W = 2 * DATA_W;

    logic signed [PROD_W-1:0] mult;
    logic [PROD_W-1:0]        mask_sel;

    // signed multiply of the operand pair
    assign mult     = $signed(wt) * $signed(act);
    assign prod_raw = mult;

    // AND-OR select of the granted mask
    always_comb begin
        mask_sel = '0;
        for (int i = 0; i < NPAT; i++) begin
            mask_sel = mask_sel | ({PROD_W{grant[i]}} & SIG_MASK[i*PROD_W +: PROD_W]);
        end
    end

    // apply the bit flips
    assign prod_mod = prod_raw ^ mask_sel;
endmodule

// File: rtl/mac_sig_pe.sv
// Weight-stationary MAC processing element with a hidden operand-pair
// signature. One register stage: the activation, the valid flag and the
// updated partial sum appear one cycle after a valid beat.
// Assumes a synchronous active-low reset and psum flowing in from one neighbour.
module mac_sig_pe
    import mac_sig_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int ACC_W  = DEF_ACC_W,
    parameter int NPAT   = DEF_NPAT,
    parameter int CNT_W  = DEF_CNT_W,
    parameter logic [NPAT*DATA_W-1:0]   SIG_WT   = DEF_SIG_WT,
    parameter logic [NPAT*DATA_W-1:0]   SIG_ACT  = DEF_SIG_ACT,
    parameter logic [NPAT*2*DATA_W-1:0] SIG_MASK = DEF_SIG_MASK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wt_load,
    input  logic [DATA_W-1:0] wt_in,
    input  logic [DATA_W-1:0] act_in,
    input  logic              act_valid_in,
    input  logic [ACC_W-1:0]  psum_in,
    output logic [DATA_W-1:0] act_out,
    output logic              act_valid_out,
    output logic [ACC_W-1:0]  psum_out,
    output logic [CNT_W-1:0]  trig_count
);
    localparam int PROD_W = 2 * DATA_W;

    logic [DATA_W-1:0] weight_q;
    logic [NPAT-1:0]   grant;
    logic              hit;
    logic [PROD_W-1:0] prod_raw;
    logic [PROD_W-1:0] prod_mod;
    logic [ACC_W-1:0]  psum_next;

    sig_trigger #(
        .DATA_W (DATA_W), .NPAT (NPAT), .SIG_WT (SIG_WT), .SIG_ACT (SIG_ACT)
    ) u_trig (
        .wt (weight_q), .act (act_in), .grant (grant), .hit (hit)
    );

    sig_payload #(
        .DATA_W (DATA_W), .NPAT (NPAT), .SIG_MASK (SIG_MASK)
    ) u_pay (
        .wt (weight_q), .act (act_in), .grant (grant),
        .prod_raw (prod_raw), .prod_mod (prod_mod)
    );

    // sign-extend the (possibly flipped) product and accumulate
    assign psum_next = psum_in + {{(ACC_W-PROD_W){prod_mod[PROD_W-1]}}, prod_mod};

    // resident weight register
    always_ff @(posedge clk) begin
        if (!rst_n)       weight_q <= '0;
        else if (wt_load) weight_q <= wt_in;
    end

    // output stage: forward activation and registered partial sum
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_out       <= '0;
            act_valid_out <= 1'b0;
            psum_out      <= '0;
        end else begin
            act_valid_out <= act_valid_in;
            if (act_valid_in) begin
                act_out  <= act_in;
                psum_out <= psum_next;
            end
        end
    end

    // debug count of signature events
    always_ff @(posedge clk) begin
        if (!rst_n)                  trig_count <= '0;
        else if (act_valid_in && hit) trig_count <= trig_count + 1'b1;
    end

    // R5
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R3
    nohit_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (prod_mod == prod_raw));

    // R4
    hit_flips_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ($countones(grant) == 1));

    // R6
    fwd_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid_in |=> (act_valid_out && act_out == $past(act_in)));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !act_valid_in |=> (!act_valid_out && $stable(psum_out) && $stable(act_out)));

    // R8
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid_in && hit) |=> (trig_count == $past(trig_count) + 1'b1));

    // R8
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(act_valid_in && hit) |=> $stable(trig_count));

    // R2
    wt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wt_load |=> $stable(weight_q));
endmodule

// File: tb/sim_mac_sig_pe.sv
// Scoreboard bench: the driver queues expected results, the monitor
// compares them at the falling edge after the producing rising edge.
module sim_mac_sig_pe;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wt_load = 1'b0;
    logic [7:0]  wt_in = '0;
    logic [7:0]  act_in = '0;
    logic        act_valid_in = 1'b0;
    logic [31:0] psum_in = '0;
    logic [7:0]  act_out;
    logic        act_valid_out;
    logic [31:0] psum_out;
    logic [15:0] trig_count;

    int checks = 0;
    int failures = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    typedef struct packed {
        logic [31:0] psum;
        logic [7:0]  act;
        logic [15:0] cnt;
        logic        sig;
    } exp_t;
    exp_t q[$];

    logic [7:0]  m_wt = '0;
    logic [15:0] m_cnt = '0;
    logic [31:0] last_psum = '0;
    logic [7:0]  last_act = '0;
    logic [15:0] last_cnt = '0;

    always #4 clk = ~clk;

    mac_sig_pe u0 (
        .clk (clk), .rst_n (rst_n), .wt_load (wt_load), .wt_in (wt_in),
        .act_in (act_in), .act_valid_in (act_valid_in), .psum_in (psum_in),
        .act_out (act_out), .act_valid_out (act_valid_out),
        .psum_out (psum_out), .trig_count (trig_count)
    );

    function automatic logic [15:0] ref_mask(input logic [7:0] w, input logic [7:0] a);
        if (w == 8'h5A && a == 8'hC3) return 16'h8001;
        if (w == 8'h81 && a == 8'h7F) return 16'h0400;
        if (w == 8'h7F && a == 8'h80) return 16'hFFFF;
        return 16'h0000;
    endfunction

    function automatic logic ref_hit(input logic [7:0] w, input logic [7:0] a);
        return (w == 8'h5A && a == 8'hC3) || (w == 8'h81 && a == 8'h7F) ||
               (w == 8'h7F && a == 8'h80);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act_v,
                         input logic [31:0] exp_v);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
        end
    endtask

    // one beat: drive at a falling edge, queue the result if valid
    task automatic beat(input bit v, input logic [7:0] a, input logic [31:0] ps,
                        input bit ld, input logic [7:0] w);
        exp_t e;
        logic [15:0] p;
        @(negedge clk);
        act_valid_in = v; act_in = a; psum_in = ps; wt_load = ld; wt_in = w;
        if (v) begin
            p = 16'($signed(m_wt) * $signed(a));
            p = p ^ ref_mask(m_wt, a);
            if (ref_hit(m_wt, a)) m_cnt = m_cnt + 16'd1;
            e.psum = ps + {{16{p[15]}}, p};
            e.act  = a;
            e.cnt  = m_cnt;
            e.sig  = ref_hit(m_wt, a);
            q.push_back(e);
        end
        if (ld) m_wt = w;
    endtask

    // monitor: compare due results, check holds on idle cycles
    always @(negedge clk) begin
        if (mon_on) begin
            if (act_valid_out) begin
                if (q.size() == 0) begin
                    check(1'b0, "R6 unexpected valid", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(psum_out == e.psum, e.sig ? "R4/R5 psum" : "R3 psum", psum_out, e.psum);
                    check(act_out == e.act, "R6 act_out", 32'(act_out), 32'(e.act));
                    check(trig_count == e.cnt, "R8 trig_count", 32'(trig_count), 32'(e.cnt));
                    last_psum = psum_out; last_act = act_out; last_cnt = trig_count;
                end
            end else begin
                check(psum_out == last_psum, "R7 psum hold", psum_out, last_psum);
                check(act_out == last_act, "R7 act hold", 32'(act_out), 32'(last_act));
                check(trig_count == last_cnt, "R7 cnt hold", 32'(trig_count), 32'(last_cnt));
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(psum_out == 0, "R1 psum_out", psum_out, 0);
        check(act_out == 0, "R1 act_out", 32'(act_out), 0);
        check(act_valid_out == 0, "R1 act_valid_out", 32'(act_valid_out), 0);
        check(trig_count == 0, "R1 trig_count", 32'(trig_count), 0);
        mon_on = 1'b1;
        // R1 weight cleared: product with weight 0 leaves psum
        beat(1, 8'h55, 32'd77, 0, 0);
        // R2 load weight 3, then plain MACs (R3)
        beat(0, 0, 0, 1, 8'd3);
        beat(1, 8'd5, 32'd100, 0, 0);
        beat(1, 8'hF9, 32'hFFFF_FFFF, 0, 0);
        // R2 load in the same cycle as a beat uses the old weight
        beat(1, 8'd10, 32'd0, 1, 8'h80);
        // R3 extreme product with wrap
        beat(1, 8'h80, 32'h7FFF_FFF0, 0, 0);
        // R4/R5 signature pair shared by entries 0 and 1
        beat(0, 0, 0, 1, 8'h5A);
        beat(1, 8'hC3, 32'd1000, 0, 0);
        // R3 near miss on the activation
        beat(1, 8'hC2, 32'd1000, 0, 0);
        // R7 matching pair without valid is ignored
        beat(0, 8'hC3, 32'd5, 0, 0);
        beat(0, 8'hC3, 32'd5, 0, 0);
        // R4 entry 2
        beat(0, 0, 0, 1, 8'h81);
        beat(1, 8'h7F, 32'd0, 0, 0);
        // R4 entry 3, every product bit flipped
        beat(0, 0, 0, 1, 8'h7F);
        beat(1, 8'h80, 32'h1234_5678, 0, 0);
        beat(1, 8'h80, 32'd0, 0, 0);
        // R3/R8 mixed traffic, with signature pairs sprinkled in
        for (int i = 0; i < 400; i++) begin
            logic [7:0] a;
            logic [7:0] w;
            a = 8'($urandom);
            w = 8'($urandom);
            if (i % 37 == 5) begin w = 8'h5A; end
            if (i % 37 == 6) begin a = 8'hC3; end
            beat(($urandom % 4) != 0, a, $urandom, (i % 9 == 0) || (i % 37 == 5), w);
        end
        beat(0, 0, 0, 0, 0);
        beat(0, 0, 0, 0, 0);
        @(negedge clk);
        check(q.size() == 0, "R6 queue drained", q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule